// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-only first-level cache. Its main store is direct-mapped. A small fully-associative side buffer sits on the refill path beside it. Each request carries a line address. The registered address is looked up in both structures at once. A hit in the main array answers on the next cycle. A hit in the side buffer answers one cycle later, and the line is moved or copied into the main array while that happens. A miss in both structures sends one line read to the next memory level. The requester is then stalled until the data comes back.

A per-request policy input chooses what the side buffer receives. In victim mode it takes the line pushed out of the main array. On a side-buffer hit, the buffered line and the current occupant of the direct-mapped slot trade places. In copy mode it takes a second copy of each line fetched from memory. On a side-buffer hit, the buffered line is copied into the main array and also stays in the buffer. Entries in the side buffer are replaced in least-recently-used order, and each entry is matched on the whole line address.

Top module: `dm_victim_cache`

## Requirements
- R1: After reset, every main-array slot and every side-buffer entry is invalid, and `busy`, `resp_valid` and `mem_req_valid` are low. The first access to any address after reset is a miss.
- R2: A request accepted at a clock edge (`req_valid` high while `busy` is low) that hits the main array raises `resp_valid` at the next edge, with the stored line and no memory read.
- R3: A request that misses the main array but hits the side buffer raises `resp_valid` exactly one cycle later than a main hit would, with no memory read. The line is then held in the main array, so an immediate repeat of the request is a main hit.
- R4: A request that misses both structures raises `mem_req_valid` for exactly one cycle, one edge after acceptance, with `mem_req_addr` equal to the request address. `resp_valid` rises at the edge that samples `mem_resp_valid`, and `resp_data` then carries `mem_resp_data`.
- R5: In victim mode (`mode` = 0), a miss moves the valid line it displaces from the main array into the side buffer. The requested line is not placed in the buffer.
- R6: In victim mode, a side-buffer hit puts the displaced main line (if it is valid) into the same buffer entry that held the requested line. If the displaced line is not valid, that entry is freed.
- R7: In copy mode (`mode` = 1), a miss writes the fetched line into both the main array and the side buffer.
- R8: In copy mode, a side-buffer hit copies the line into the main array and leaves it valid in the buffer.
- R9: A line written into the side buffer goes to the entry that already holds the same address if there is one. Otherwise it goes to the lowest-numbered invalid entry, and otherwise to the least-recently-used entry. A buffer write and a copy-mode buffer hit each count as a use of that entry.
- R10: Side-buffer entries compare all `ADDR_W` address bits. Two lines with the same index but different tags never match each other.
- R11: `busy` is high from the edge after acceptance until the response edge, and low in the response cycle. A `req_valid` presented while `busy` is high is ignored.
- R12: The `mode` value is sampled with the request at acceptance. Changing `mode` later in the same access has no effect on that access.
- R13: The side buffer never holds two valid entries with the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | Fill policy: 0 victim, 1 copy of requested line |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_addr | input | ADDR_W (12) | Requested line address; the low INDEX_W bits select the slot |
| busy | output | 1 | Request in progress; new requests ignored |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | LINE_W (32) | Returned line |
| mem_req_valid | output | 1 | One-cycle line read request to the next level |
| mem_req_addr | output | ADDR_W (12) | Line address of the read |
| mem_resp_valid | input | 1 | Refill data valid |
| mem_resp_data | input | LINE_W (32) | Refill line |

## Verification
Most wrong internal state in this block does not corrupt data, because a line's contents depend only on its address. It shows up at the ports as a wrong timing class on a later access. If a buffer entry is lost, if a swap goes to the wrong entry, or if the LRU order is off, a later request that should answer in two or three cycles becomes a memory read instead. A stale or duplicated entry can also turn an expected miss into an early answer. Such an error shows up the first time the affected address is requested again, which is usually within a few accesses under conflict-heavy traffic on a small address space. A wrong line stored into the main array shows up on the next hit to that slot as a `resp_data` mismatch.

// File: rtl/dmvc_pkg.sv
package dmvc_pkg;

    localparam int unsigned DEF_ADDR_W     = 12;
    localparam int unsigned DEF_INDEX_W    = 3;
    localparam int unsigned DEF_LINE_W     = 32;
    localparam int unsigned DEF_SIDE_DEPTH = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_SWAP = 2'd2,
        ST_FILL = 2'd3
    } vc_state_e;

    typedef enum logic {
        FILL_VICTIM   = 1'b0,
        FILL_MISSCOPY = 1'b1
    } vc_policy_e;

    typedef enum logic [1:0] {
        LK_MAIN = 2'd0,
        LK_SIDE = 2'd1,
        LK_NONE = 2'd2
    } vc_lookup_e;

    function automatic int unsigned way_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic vc_lookup_e classify(input logic main_hit, input logic side_hit);
        if (main_hit)      return LK_MAIN;
        else if (side_hit) return LK_SIDE;
        else               return LK_NONE;
    endfunction

endpackage

// File: rtl/vc_direct_array.sv
module vc_direct_array
    import dmvc_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned INDEX_W = DEF_INDEX_W,
    parameter int unsigned LINE_W  = DEF_LINE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [INDEX_W-1:0]        rd_idx,
    output logic                      rd_valid,
    output logic [ADDR_W-INDEX_W-1:0] rd_tag,
    output logic [LINE_W-1:0]         rd_data,
    input  logic                      wr_en,
    input  logic [INDEX_W-1:0]        wr_idx,
    input  logic [ADDR_W-INDEX_W-1:0] wr_tag,
    input  logic [LINE_W-1:0]         wr_data
);
    localparam int unsigned TAG_W = ADDR_W - INDEX_W;
    localparam int unsigned SETS  = 1 << INDEX_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] data;
    } slot_t;

    logic [SETS-1:0] valid_q;
    slot_t           slot_q [SETS];

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = slot_q[rd_idx].tag;
    assign rd_data  = slot_q[rd_idx].data;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot_q[wr_idx] <= '{tag: wr_tag, data: wr_data};
        end
    end

    // R1
    main_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0))
        else $error("main array not cleared by reset");

endmodule

// File: rtl/vc_lru_order.sv
module vc_lru_order
    import dmvc_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_SIDE_DEPTH
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        touch_en,
    input  logic [way_bits(DEPTH)-1:0]  touch_way,
    output logic [way_bits(DEPTH)-1:0]  lru_way
);
    localparam int unsigned WAY_W = way_bits(DEPTH);

    logic [WAY_W-1:0] rank_q [DEPTH];
    logic [DEPTH-1:0] oldest_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) begin
                rank_q[j] <= WAY_W'(j);
            end
        end else if (touch_en) begin
            for (int j = 0; j < DEPTH; j++) begin
                if (WAY_W'(j) == touch_way) begin
                    rank_q[j] <= '0;
                end else if (rank_q[j] < rank_q[touch_way]) begin
                    rank_q[j] <= rank_q[j] + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        assign oldest_vec[g] = (rank_q[g] == WAY_W'(DEPTH - 1));
    end

    always_comb begin
        lru_way = '0;
        for (int j = DEPTH - 1; j >= 0; j--) begin
            if (oldest_vec[j]) lru_way = WAY_W'(j);
        end
    end

    // R9
    lru_single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest_vec) == 1)
        else $error("LRU order lost its single oldest entry");

    // R9
    lru_touched_not_oldest_chk: assert property (@(posedge clk) disable iff (rst)
        (touch_en && (DEPTH > 1)) |=> (lru_way != $past(touch_way)))
        else $error("most recently used entry chosen for replacement");

endmodule

// File: rtl/vc_side_buffer.sv
module vc_side_buffer
    import dmvc_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned LINE_W = DEF_LINE_W,
    parameter int unsigned DEPTH  = DEF_SIDE_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          lk_addr,
    output logic                       hit,
    output logic [way_bits(DEPTH)-1:0] hit_way,
    output logic [LINE_W-1:0]          hit_data,
    input  logic [ADDR_W-1:0]          ins_addr,
    input  logic [way_bits(DEPTH)-1:0] lru_way,
    output logic [way_bits(DEPTH)-1:0] ins_way,
    input  logic                       wr_en,
    input  logic [way_bits(DEPTH)-1:0] wr_way,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [LINE_W-1:0]          wr_data,
    input  logic                       inv_en,
    input  logic [way_bits(DEPTH)-1:0] inv_way
);
    localparam int unsigned WAY_W = way_bits(DEPTH);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] data;
    } entry_t;

    logic [DEPTH-1:0] valid_q, valid_d;
    entry_t           ent_q [DEPTH];
    logic [DEPTH-1:0] hit_vec, same_vec, free_vec, dup_vec;
    logic [WAY_W-1:0] same_way, free_way;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g]  = valid_q[g] && (ent_q[g].addr == lk_addr);
        assign same_vec[g] = valid_q[g] && (ent_q[g].addr == ins_addr);
        assign free_vec[g] = !valid_q[g];
        assign dup_vec[g]  = wr_en && valid_q[g] && (ent_q[g].addr == wr_addr)
                             && (WAY_W'(g) != wr_way);
    end

    always_comb begin
        hit_way  = '0;
        same_way = '0;
        free_way = '0;
        for (int j = DEPTH - 1; j >= 0; j--) begin
            if (hit_vec[j])  hit_way  = WAY_W'(j);
            if (same_vec[j]) same_way = WAY_W'(j);
            if (free_vec[j]) free_way = WAY_W'(j);
        end
    end

    assign hit      = |hit_vec;
    assign hit_data = ent_q[hit_way].data;

    always_comb begin
        if (|same_vec)      ins_way = same_way;
        else if (|free_vec) ins_way = free_way;
        else                ins_way = lru_way;
    end

    always_comb begin
        valid_d = valid_q & ~dup_vec;
        if (inv_en) valid_d[inv_way] = 1'b0;
        if (wr_en)  valid_d[wr_way]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) valid_q <= '0;
        else     valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_q[wr_way] <= '{addr: wr_addr, data: wr_data};
        end
    end

    // R13
    side_unique_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(hit_vec) <= 1)
        else $error("side buffer holds a duplicated address");

    // R1
    side_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0))
        else $error("side buffer not cleared by reset");

    // R9
    side_insert_free_first_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(|same_vec) && (|free_vec) && (ins_addr == wr_addr))
            |-> !valid_q[wr_way])
        else $error("valid entry overwritten while a free entry existed");

endmodule

// File: rtl/vc_control.sv
module vc_control
    import dmvc_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned INDEX_W = DEF_INDEX_W,
    parameter int unsigned LINE_W  = DEF_LINE_W,
    parameter int unsigned WAY_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      mode,
    output logic                      busy,
    output logic                      resp_valid,
    output logic [LINE_W-1:0]         resp_data,
    output logic                      mem_req_valid,
    input  logic                      mem_resp_valid,
    input  logic [LINE_W-1:0]         mem_resp_data,
    output logic [ADDR_W-1:0]         look_addr,
    input  logic                      main_valid,
    input  logic [ADDR_W-INDEX_W-1:0] main_tag,
    input  logic [LINE_W-1:0]         main_data,
    output logic                      main_wr_en,
    output logic [LINE_W-1:0]         main_wr_data,
    input  logic                      side_hit,
    input  logic [WAY_W-1:0]          side_way,
    input  logic [LINE_W-1:0]         side_data,
    input  logic [WAY_W-1:0]          ins_way,
    output logic [ADDR_W-1:0]         ins_addr,
    output logic                      side_wr_en,
    output logic [WAY_W-1:0]          side_wr_way,
    output logic [ADDR_W-1:0]         side_wr_addr,
    output logic [LINE_W-1:0]         side_wr_data,
    output logic                      side_inv_en,
    output logic                      lru_touch_en,
    output logic [WAY_W-1:0]          lru_touch_way
);
    localparam int unsigned TAG_W = ADDR_W - INDEX_W;

    vc_state_e        state_q;
    vc_policy_e       policy_q;
    logic [ADDR_W-1:0] addr_q;

    logic [INDEX_W-1:0] idx;
    logic [TAG_W-1:0]   tag;
    logic               main_hit;
    logic [ADDR_W-1:0]  old_addr;
    vc_lookup_e         outcome;
    logic               copy_touch;

    assign idx       = addr_q[INDEX_W-1:0];
    assign tag       = addr_q[ADDR_W-1:INDEX_W];
    assign main_hit  = main_valid && (main_tag == tag);
    assign old_addr  = {main_tag, idx};
    assign outcome   = classify(main_hit, side_hit);
    assign look_addr = addr_q;
    assign busy      = (state_q != ST_IDLE);

    always_comb begin
        main_wr_en   = 1'b0;
        main_wr_data = mem_resp_data;
        ins_addr     = addr_q;
        side_wr_en   = 1'b0;
        side_wr_way  = side_way;
        side_wr_addr = old_addr;
        side_wr_data = main_data;
        side_inv_en  = 1'b0;
        copy_touch   = 1'b0;
        case (state_q)
            ST_SWAP: begin
                main_wr_en   = 1'b1;
                main_wr_data = side_data;
                if (policy_q == FILL_VICTIM) begin
                    if (main_valid) side_wr_en  = 1'b1;
                    else            side_inv_en = 1'b1;
                end else begin
                    copy_touch = 1'b1;
                end
            end
            ST_FILL: begin
                if (mem_resp_valid) begin
                    main_wr_en  = 1'b1;
                    side_wr_way = ins_way;
                    if (policy_q == FILL_VICTIM) begin
                        ins_addr   = old_addr;
                        side_wr_en = main_valid;
                    end else begin
                        side_wr_en   = 1'b1;
                        side_wr_addr = addr_q;
                        side_wr_data = mem_resp_data;
                    end
                end
            end
            default: ;
        endcase
    end

    assign lru_touch_en  = side_wr_en | copy_touch;
    assign lru_touch_way = side_wr_way;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            policy_q      <= FILL_VICTIM;
            addr_q        <= '0;
            resp_valid    <= 1'b0;
            resp_data     <= '0;
            mem_req_valid <= 1'b0;
        end else begin
            resp_valid    <= 1'b0;
            mem_req_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q   <= req_addr;
                        policy_q <= vc_policy_e'(mode);
                        state_q  <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    case (outcome)
                        LK_MAIN: begin
                            resp_valid <= 1'b1;
                            resp_data  <= main_data;
                            state_q    <= ST_IDLE;
                        end
                        LK_SIDE: state_q <= ST_SWAP;
                        default: begin
                            mem_req_valid <= 1'b1;
                            state_q       <= ST_FILL;
                        end
                    endcase
                end
                ST_SWAP: begin
                    resp_valid <= 1'b1;
                    resp_data  <= side_data;
                    state_q    <= ST_IDLE;
                end
                ST_FILL: begin
                    if (mem_resp_valid) begin
                        resp_valid <= 1'b1;
                        resp_data  <= mem_resp_data;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    main_hit_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOK && main_hit) |=> (resp_valid && resp_data == $past(main_data)))
        else $error("main hit did not answer on the next cycle");

    // R3
    side_hit_extra_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOOK && !main_hit && side_hit) |=> (!resp_valid && !mem_req_valid))
        else $error("side hit answered early or read memory");

    // R3
    swap_then_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SWAP) |=> (resp_valid && resp_data == $past(side_data)))
        else $error("swap cycle did not answer");

    // R4
    single_mem_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid)
        else $error("memory read held for more than one cycle");

    // R4
    mem_read_while_waiting_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (state_q == ST_FILL))
        else $error("memory read outside refill wait");

    // R11
    resp_ends_stall_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !busy)
        else $error("response while still busy");

    // R11
    busy_ignores_request_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(addr_q))
        else $error("request taken while busy");

endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache
    import dmvc_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned INDEX_W    = DEF_INDEX_W,
    parameter int unsigned LINE_W     = DEF_LINE_W,
    parameter int unsigned SIDE_DEPTH = DEF_SIDE_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              resp_valid,
    output logic [LINE_W-1:0] resp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [LINE_W-1:0] mem_resp_data
);
    localparam int unsigned TAG_W = ADDR_W - INDEX_W;
    localparam int unsigned WAY_W = way_bits(SIDE_DEPTH);

    logic [ADDR_W-1:0] look_addr;
    logic              main_valid;
    logic [TAG_W-1:0]  main_tag;
    logic [LINE_W-1:0] main_data;
    logic              main_wr_en;
    logic [LINE_W-1:0] main_wr_data;
    logic              side_hit;
    logic [WAY_W-1:0]  side_way;
    logic [LINE_W-1:0] side_data;
    logic [WAY_W-1:0]  ins_way;
    logic [ADDR_W-1:0] ins_addr;
    logic              side_wr_en;
    logic [WAY_W-1:0]  side_wr_way;
    logic [ADDR_W-1:0] side_wr_addr;
    logic [LINE_W-1:0] side_wr_data;
    logic              side_inv_en;
    logic              lru_touch_en;
    logic [WAY_W-1:0]  lru_touch_way;
    logic [WAY_W-1:0]  lru_way;

    assign mem_req_addr = look_addr;

    vc_direct_array #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .LINE_W(LINE_W)) u_main (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (look_addr[INDEX_W-1:0]),
        .rd_valid (main_valid),
        .rd_tag   (main_tag),
        .rd_data  (main_data),
        .wr_en    (main_wr_en),
        .wr_idx   (look_addr[INDEX_W-1:0]),
        .wr_tag   (look_addr[ADDR_W-1:INDEX_W]),
        .wr_data  (main_wr_data)
    );

    vc_side_buffer #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .DEPTH(SIDE_DEPTH)) u_side (
        .clk      (clk),
        .rst      (rst),
        .lk_addr  (look_addr),
        .hit      (side_hit),
        .hit_way  (side_way),
        .hit_data (side_data),
        .ins_addr (ins_addr),
        .lru_way  (lru_way),
        .ins_way  (ins_way),
        .wr_en    (side_wr_en),
        .wr_way   (side_wr_way),
        .wr_addr  (side_wr_addr),
        .wr_data  (side_wr_data),
        .inv_en   (side_inv_en),
        .inv_way  (side_way)
    );

    vc_lru_order #(.DEPTH(SIDE_DEPTH)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (lru_touch_en),
        .touch_way (lru_touch_way),
        .lru_way   (lru_way)
    );

    vc_control #(
        .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .LINE_W(LINE_W), .WAY_W(WAY_W)
    ) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .mode           (mode),
        .busy           (busy),
        .resp_valid     (resp_valid),
        .resp_data      (resp_data),
        .mem_req_valid  (mem_req_valid),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .look_addr      (look_addr),
        .main_valid     (main_valid),
        .main_tag       (main_tag),
        .main_data      (main_data),
        .main_wr_en     (main_wr_en),
        .main_wr_data   (main_wr_data),
        .side_hit       (side_hit),
        .side_way       (side_way),
        .side_data      (side_data),
        .ins_way        (ins_way),
        .ins_addr       (ins_addr),
        .side_wr_en     (side_wr_en),
        .side_wr_way    (side_wr_way),
        .side_wr_addr   (side_wr_addr),
        .side_wr_data   (side_wr_data),
        .side_inv_en    (side_inv_en),
        .lru_touch_en   (lru_touch_en),
        .lru_touch_way  (lru_touch_way)
    );

    // R1
    top_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !resp_valid && !mem_req_valid))
        else $error("outputs active right after reset");

endmodule

// File: tb/dm_victim_cache_test.sv
module dm_victim_cache_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int IW = 3;
    localparam int LW = 32;
    localparam int SD = 4;
    localparam int MEM_LAT = 3;
    localparam int SETS = 1 << IW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          busy, resp_valid, mem_req_valid;
    logic [LW-1:0] resp_data;
    logic [AW-1:0] mem_req_addr;
    logic          mem_resp_valid = 1'b0;
    logic [LW-1:0] mem_resp_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // bench model: 0 main hit, 1 side hit, 2 miss
    bit          m_val  [SETS];
    logic [AW-1:0] m_addr [SETS];
    bit          s_val  [SD];
    logic [AW-1:0] s_addr [SD];
    int          s_rank [SD];

    dm_victim_cache uut (
        .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [LW-1:0] mem_line(input logic [AW-1:0] a);
        return {4'hC, a, a ^ 12'h5A3, a[3:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < SETS; i++) begin m_val[i] = 0; m_addr[i] = '0; end
        for (int j = 0; j < SD; j++) begin s_val[j] = 0; s_addr[j] = '0; s_rank[j] = j; end
    endtask

    task automatic touch(input int w);
        int r = s_rank[w];
        for (int j = 0; j < SD; j++) if (s_rank[j] < r) s_rank[j]++;
        s_rank[w] = 0;
    endtask

    function automatic int choose(input logic [AW-1:0] x);
        for (int j = 0; j < SD; j++) if (s_val[j] && s_addr[j] == x) return j;
        for (int j = 0; j < SD; j++) if (!s_val[j]) return j;
        for (int j = 0; j < SD; j++) if (s_rank[j] == SD - 1) return j;
        return 0;
    endfunction

    task automatic side_write(input int w, input logic [AW-1:0] x);
        for (int j = 0; j < SD; j++) if (j != w && s_val[j] && s_addr[j] == x) s_val[j] = 0;
        s_addr[w] = x;
        s_val[w] = 1;
        touch(w);
    endtask

    function automatic int predict(input logic [AW-1:0] a);
        int idx = int'(a[IW-1:0]);
        if (m_val[idx] && m_addr[idx] == a) return 0;
        for (int j = 0; j < SD; j++) if (s_val[j] && s_addr[j] == a) return 1;
        return 2;
    endfunction

    task automatic model_update(input logic [AW-1:0] a, input logic md, input int cls);
        int idx = int'(a[IW-1:0]);
        int w;
        if (cls == 1) begin
            w = 0;
            for (int j = 0; j < SD; j++) if (s_val[j] && s_addr[j] == a) w = j;
            if (md == 1'b0) begin
                if (m_val[idx]) side_write(w, m_addr[idx]);
                else s_val[w] = 0;
            end else begin
                touch(w);
            end
        end else if (cls == 2) begin
            if (md == 1'b0) begin
                if (m_val[idx]) begin
                    w = choose(m_addr[idx]);
                    side_write(w, m_addr[idx]);
                end
            end else begin
                w = choose(a);
                side_write(w, a);
            end
        end
        m_val[idx]  = 1;
        m_addr[idx] = a;
    endtask

    // One access; mode is flipped after acceptance (R12). poke drives a stray request while busy (R11).
    task automatic do_access(input logic [AW-1:0] a, input logic md, input string tag, input bit poke);
        int exp_cls = predict(a);
        int exp_lat = (exp_cls == 0) ? 2 : (exp_cls == 1) ? 3 : 2 + MEM_LAT;
        int lat = 1;
        int nreq = 0;
        int pend = 0;
        bit got = 0;
        bit busy_ok = 1;
        logic [AW-1:0] seen_addr = '0;
        logic [LW-1:0] data = '0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; mode = md;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; mode = ~md;
        while (!got && lat < 64) begin
            if (resp_valid) begin
                got = 1; data = resp_data;
                if (busy) busy_ok = 0;
            end else begin
                if (!busy) busy_ok = 0;
                if (mem_req_valid) begin nreq++; seen_addr = mem_req_addr; pend = MEM_LAT; end
                if (mem_resp_valid) mem_resp_valid = 1'b0;
                if (poke && lat == 3) begin req_valid = 1'b1; req_addr = a ^ 12'h0F0; end
                if (poke && lat == 4) req_valid = 1'b0;
                if (pend > 0) begin
                    pend--;
                    if (pend == 0) begin mem_resp_valid = 1'b1; mem_resp_data = mem_line(seen_addr); end
                end
                @(negedge clk);
                lat++;
            end
        end
        mem_resp_valid = 1'b0;
        req_valid = 1'b0;
        check(got && lat == exp_lat, tag, "latency", lat, exp_lat);
        check(data == mem_line(a), tag, "data", data, mem_line(a));
        check(nreq == ((exp_cls == 2) ? 1 : 0), tag, "memory reads", nreq, (exp_cls == 2) ? 1 : 0);
        if (nreq == 1) check(seen_addr == a, tag, "read address", seen_addr, a);
        check(busy_ok, "R11", "busy window", busy_ok, 1);
        model_update(a, md, exp_cls);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fail++; n_checks++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd7919));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1: quiet outputs after reset
        check(!busy && !resp_valid && !mem_req_valid, "R1", "reset outputs",
              {busy, resp_valid, mem_req_valid}, 0);

        do_access(12'h000, 1'b0, "R1", 0);   // first access misses
        do_access(12'h000, 1'b0, "R2", 0);   // main hit
        do_access(12'h008, 1'b0, "R5", 0);   // miss, 0x000 moves to side buffer
        do_access(12'h000, 1'b0, "R5", 0);   // side hit proves displacement
        do_access(12'h008, 1'b0, "R6", 0);   // swap put 0x008 into the buffer
        do_access(12'h008, 1'b0, "R3", 0);   // repeat is a main hit
        do_access(12'h800, 1'b0, "R10", 0);  // same index, differing top bit: miss
        do_access(12'h000, 1'b0, "R10", 0);
        do_access(12'h010, 1'b1, "R7", 0);   // copy mode miss
        do_access(12'h018, 1'b1, "R7", 0);
        do_access(12'h010, 1'b1, "R7", 0);   // hit in side buffer
        do_access(12'h010, 1'b1, "R8", 0);   // now in main
        do_access(12'h018, 1'b1, "R8", 0);   // still in buffer
        do_access(12'h010, 1'b1, "R8", 0);   // stays in buffer after copy
        for (int k = 0; k < 7; k++) do_access(AW'((k << IW) | 1), 1'b0, "R9", 0);
        for (int k = 0; k < 7; k++) do_access(AW'((k << IW) | 1), 1'b0, "R9", 0);
        do_access(12'h022, 1'b1, "R13", 0);  // copy mode: main and buffer
        do_access(12'h02A, 1'b0, "R13", 0);  // victim: 0x022 re-enters same entry
        do_access(12'h022, 1'b0, "R13", 0);
        do_access(12'h02A, 1'b0, "R13", 0);
        do_access(12'h033, 1'b0, "R12", 0);  // mode flipped after acceptance
        do_access(12'h03B, 1'b1, "R12", 0);
        do_access(12'h033, 1'b0, "R12", 0);
        do_access(12'h044, 1'b0, "R11", 1);  // stray request during stall
        repeat (3) begin
            @(negedge clk);
            check(!resp_valid && !mem_req_valid && !busy, "R11", "stray request ignored",
                  {resp_valid, mem_req_valid, busy}, 0);
        end

        for (int n = 0; n < 500; n++) begin
            logic [AW-1:0] a = AW'($urandom_range(0, 31));
            logic md = 1'($urandom_range(0, 1));
            int c = predict(a);
            if ($urandom_range(0, 5) == 0) a = {1'b1, a[AW-2:0]};
            c = predict(a);
            do_access(a, md, (c == 0) ? "R2" : (c == 1) ? "R3" : "R4", 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule